// File: doc/BRIEF.md
# Inverted-Load Audio Frequency Divider

This block is the programmable pitch divider of one sound channel. Software writes a 5-bit frequency code into a holding register, which keeps the code exactly as written. A 5-bit up counter is loaded with the bitwise complement of that code and advances by one on every audio clock enable. When the counter reaches all ones, the divider output goes high. On the next audio clock the counter loads the complemented code again instead of wrapping. The division ratio is therefore the code plus one. A code of zero keeps the output permanently high.

Each audio clock taken while the divider output is high starts a short sequence of two tone-clock pulses. The second-phase pulse comes first, in the clock cycle right after that audio clock. The first-phase pulse follows one audio clock later. Downstream waveform logic uses the two pulses as its stepping strobes. A new code written while a count is running takes effect only at the next reload.

Top module: `tone_freq_divider`

## Requirements
- R1: After reset, with the default reset code of 0, `div_out` is 1 and both `tone2_pulse` and `tone1_pulse` are 0.
- R2: The holding register keeps the written code N unchanged, and the counter is loaded with its bitwise complement. Over successive audio clocks `div_out` is therefore 1 in exactly one audio-clock interval out of every N+1: it shows N zeros and then a one, repeating.
- R3: With code 0, `div_out` stays at 1 across every audio clock.
- R4: With `tick` low, the counter does not advance: `div_out` holds its value and no tone pulse starts.
- R5: An audio clock (`tick` high at a rising edge) taken while `div_out` is 1 makes `tone2_pulse` high for the one following clock cycle. Otherwise `tone2_pulse` is 0.
- R6: `tone1_pulse` is high for the one clock cycle after the next audio clock that follows a `tone2_pulse` event. Otherwise it is 0.
- R7: A write while a count is in progress does not change the count in progress. The new code is used from the next reload on.
- R8: The largest code, 31, divides by 32: `div_out` is high once every 32 audio clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Audio clock enable, one system cycle per audio clock |
| wr_en | input | 1 | Write strobe for the frequency code |
| wr_data | input | 5 | Frequency code to store |
| div_out | output | 1 | Divider output, high while the counter is all ones |
| tone2_pulse | output | 1 | First pulse of the tone sequence |
| tone1_pulse | output | 1 | Second pulse of the tone sequence, one audio clock later |

## Verification
The bench runs codes 1, 2, 5, 31 and 0 and checks the `div_out` pattern after every audio clock. A design that loaded the code without complementing it, or that wrapped instead of reloading, would give the wrong run of zeros, and code 0 would stop being constantly high. Every audio clock is also checked for the order and width of both tone pulses, so a swapped or stretched pulse is reported. The bench also changes the code in the middle of a count to catch a design that reloads at once. It holds `tick` low for many cycles to catch a counter that advances without the enable.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int unsigned TFD_CODE_W = 5;

    typedef struct packed {
        logic t2;
        logic t1;
        logic pend;
    } tone_state_t;

endpackage

// File: rtl/tfd_code_reg.sv
module tfd_code_reg #(
    parameter int unsigned W          = 5,
    parameter logic [W-1:0] RESET_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] code_o
);

    typedef struct packed {
        logic [W-1:0] code;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.code = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.code <= RESET_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;

    // R2 and R7: the stored code changes only on a write.
    a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_o));

    // R2: a write stores the code unchanged.
    a_r2_code_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> code_o == $past(wr_data));

endmodule

// File: rtl/tfd_upcount.sv
module tfd_upcount #(
    parameter int unsigned W          = 5,
    parameter logic [W-1:0] RESET_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] code_i,
    output logic         full_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       at_top;

    assign at_top = (s_q.cnt == ALL_ONES);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (at_top) begin
                s_d.cnt = ~code_i;
            end else begin
                s_d.cnt = s_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= ~RESET_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign full_o = at_top;

    // R4: without an audio clock the count is frozen.
    a_r4_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));

    // R2: a tick at the top reloads the complemented code.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && full_o) |=> (s_q.cnt == ~$past(code_i)));

    // R2: a tick below the top steps the count by exactly one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !full_o) |=> (s_q.cnt == $past(s_q.cnt) + ONE));

endmodule

// File: rtl/tfd_tone_seq.sv
module tfd_tone_seq
    import tfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic full_i,
    output logic tone2_o,
    output logic tone1_o
);

    tone_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.t2 = tick & full_i;
        s_d.t1 = tick & s_q.pend;
        if (tick) begin
            s_d.pend = full_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tone2_o = s_q.t2;
    assign tone1_o = s_q.t1;

    // R5: the early pulse only follows an audio clock.
    a_r5_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tone2_o |-> $past(tick));

    // R6: the late pulse only follows an audio clock.
    a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tone1_o |-> $past(tick));

    // R6: the late pulse needs a pending early event.
    a_r6_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        tone1_o |-> $past(s_q.pend));

endmodule

// File: rtl/tone_freq_divider.sv
module tone_freq_divider #(
    parameter int unsigned W                = tfd_pkg::TFD_CODE_W,
    parameter logic [W-1:0] RESET_CODE       = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         div_out,
    output logic         tone2_pulse,
    output logic         tone1_pulse
);

    logic [W-1:0] code;
    logic         full;

    tfd_code_reg #(.W(W), .RESET_CODE(RESET_CODE)) i_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .code_o  (code)
    );

    tfd_upcount #(.W(W), .RESET_CODE(RESET_CODE)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .code_i (code),
        .full_o (full)
    );

    tfd_tone_seq i_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .full_i  (full),
        .tone2_o (tone2_pulse),
        .tone1_o (tone1_pulse)
    );

    assign div_out = full;

    // R3: with a zero code the output never drops on an audio clock.
    a_r3_zero_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && full && code == '0) |=> div_out);

endmodule

// File: tb/test_tone_freq_divider.sv
`timescale 1ns/1ps
module test_tone_freq_divider;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         div_out, tone2_pulse, tone1_pulse;

    int total = 0;
    int bad = 0;
    logic prev_db = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    tone_freq_divider #(.W(W)) i_tone_freq_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .div_out     (div_out),
        .tone2_pulse (tone2_pulse),
        .tone1_pulse (tone1_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One audio clock; checks the tone pulses (R5, R6) and returns div_out after it.
    task automatic tick_chk(output logic d_after);
        logic db;
        @(negedge clk);
        db = div_out;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R5 tone2 after tick", int'(tone2_pulse), int'(db));
        chk("R6 tone1 after tick", int'(tone1_pulse), int'(prev_db));
        prev_db = db;
        d_after = div_out;
        @(negedge clk);
        chk("R5 tone2 width", int'(tone2_pulse), 0);
        chk("R6 tone1 width", int'(tone1_pulse), 0);
    endtask

    task automatic write_code(input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go_top();
        logic d;
        for (int k = 0; k < 40 && !div_out; k++) tick_chk(d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset div_out", int'(div_out), 1);
        chk("R1 reset tone2", int'(tone2_pulse), 0);
        chk("R1 reset tone1", int'(tone1_pulse), 0);
    endtask

    task automatic t_ratio(input int n, input string req);
        logic d;
        go_top();
        write_code(n[W-1:0]);
        for (int j = 0; j < 3 * (n + 1); j++) begin
            tick_chk(d);
            chk(req, int'(d), int'((j % (n + 1)) == n));
        end
    endtask

    task automatic t_hold();
        logic d0;
        logic d;
        go_top();
        write_code(5'd3);
        tick_chk(d);
        d0 = div_out;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R4 div_out frozen without tick", int'(div_out), int'(d0));
            chk("R4 no tone2 without tick", int'(tone2_pulse), 0);
        end
        for (int j = 1; j < 8; j++) begin
            tick_chk(d);
            chk("R4 count resumes after idle", int'(d), int'((j % 4) == 3));
        end
    endtask

    task automatic t_midwrite();
        logic d;
        go_top();
        write_code(5'd5);
        for (int j = 0; j < 3; j++) tick_chk(d);
        write_code(5'd1);
        for (int j = 3; j < 6; j++) begin
            tick_chk(d);
            chk("R7 old count kept", int'(d), int'(j == 5));
        end
        for (int j = 0; j < 6; j++) begin
            tick_chk(d);
            chk("R7 new code after reload", int'(d), int'((j % 2) == 1));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ratio(1, "R2 divide by 2");
        t_ratio(2, "R2 divide by 3");
        t_ratio(5, "R2 divide by 6");
        t_ratio(31, "R8 divide by 32");
        t_ratio(0, "R3 zero code constant high");
        t_hold();
        t_midwrite();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule